// File: doc/BRIEF.md
# Branch Trace Capture Queue

This block keeps a short history of processor control transfers for debug. While the trace enable bit is set, each qualifying branch event is turned into a pair of 32-bit addresses, an origin and a landing point, and pushed into an eight-deep circular queue. For an ordinary jump, the origin is the jump instruction's address and the landing point is its target. For an interrupt or exception, the origin is the saved exception PC and the landing point is the handler's start address. A jump back from the end of a hardware repeat loop to its start is not counted as a branch.

Software inspects the history through one register-style read port. A select bit chooses between two views of the oldest entry, the origin view and the landing view, and both views share a single head pointer. The expected access order is the origin view first, then the landing view. Only a read of the landing view advances the queue.

When the queue is full, a new capture overwrites the oldest pair. Clearing the enable bit and setting it again throws away the history.

Top module: `branch_trace_queue`

## Requirements
- R1: A pair is captured only in a cycle where `ev_valid` is 1 and `trace_en` is 1. While `trace_en` is 0, events leave `fill_count` unchanged.
- R2: When `ev_kind` is 0 (a jump), the stored origin is `ev_insn_addr` and the stored landing point is `ev_target`.
- R3: When `ev_kind` is 1 (an interrupt or exception), the stored origin is `ev_saved_pc` and the stored landing point is `ev_vector`.
- R4: An event with `ev_loop_ret` set to 1 is not recorded.
- R5: The queue holds 8 pairs. A capture into a full queue discards the oldest pair, so the 8 most recent pairs remain.
- R6: A read with `rd_en` set to 1 returns data from the oldest retained pair. `rd_sel` = 0 selects the origin and `rd_sel` = 1 selects the landing point. The data appears on `rd_data` with `rd_valid` = 1 in the cycle after the read.
- R7: A read of the origin view (`rd_sel` = 0) leaves the head unchanged. A read of the landing view (`rd_sel` = 1) advances the head by one entry.
- R8: A read of an empty queue returns `rd_data` = 0 with `rd_valid` = 0 and does not change the queue. In a cycle after no read, `rd_valid` = 0 and `rd_data` = 0.
- R9: In the cycle where `trace_en` goes from 0 to 1, all stored pairs are discarded. A capture in that same cycle becomes the only entry.
- R10: When a capture and a landing-view read happen in the same cycle, both take effect, and `fill_count` ends at old count + 1 − 1. On a full queue this means only the popped pair leaves.
- R11: `fill_count` reports the number of stored pairs. After a synchronous active-low reset, the queue is empty and `rd_valid` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trace_en | input | 1 | Trace enable control bit |
| ev_valid | input | 1 | Branch event strobe |
| ev_kind | input | 1 | Event type: 0 = jump, 1 = interrupt or exception |
| ev_insn_addr | input | 32 | Address of the branch instruction |
| ev_target | input | 32 | Address of the branch target |
| ev_saved_pc | input | 32 | Saved exception PC |
| ev_vector | input | 32 | Start address of the exception handler |
| ev_loop_ret | input | 1 | Event is a return from the end of a repeat loop |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Read view: 0 = origin, 1 = landing point |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read returned a stored entry |
| fill_count | output | 4 | Number of stored pairs |

## Verification
The bench targets six corner cases, each with the wrong behaviour it would expose:
- **Capture into a full queue.** A design that stops accepting new pairs keeps stale history. A design that advances the wrong pointer returns pairs out of order.
- **Repeated origin-view reads.** A design that pops on the origin view skips entries.
- **Re-enable while holding history, including a capture in that same cycle.** A design that misses the flush returns old pairs. A design that gives the flush priority over the write loses the new pair.
- **Simultaneous capture and landing-view read, on a partly filled and on a full queue.** A wrong design drifts `fill_count` or drops a pair.
- **Empty reads.** A wrong design returns stale data or moves the pointer.
- **Swapped exception fields.** A design that uses the wrong exception fields stores the instruction address in place of the saved PC.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int TRC_AW = 32;

  typedef enum logic {
    EV_JUMP = 1'b0,
    EV_TRAP = 1'b1
  } ev_kind_e;

  typedef struct packed {
    logic [TRC_AW-1:0] origin;
    logic [TRC_AW-1:0] landing;
  } trc_pair_t;

  // Circular pointer increment for any depth
  function automatic int unsigned ptr_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle; pop is only asserted when non-empty
  function automatic int unsigned count_next(input int unsigned c, input logic push,
                                             input logic pop, input int unsigned depth);
    if (push && pop) return c;
    if (push)        return (c == depth) ? c : c + 1;
    if (pop)         return c - 1;
    return c;
  endfunction
endpackage

// File: rtl/trc_select.sv
module trc_select
  import trc_pkg::*;
(
  input  logic              trace_en,
  input  logic              ev_valid,
  input  ev_kind_e          ev_kind,
  input  logic [TRC_AW-1:0] ev_insn_addr,
  input  logic [TRC_AW-1:0] ev_target,
  input  logic [TRC_AW-1:0] ev_saved_pc,
  input  logic [TRC_AW-1:0] ev_vector,
  input  logic              ev_loop_ret,
  output logic              cap_fire,
  output trc_pair_t         cap_pair
);
  always_comb begin
    cap_fire = ev_valid && trace_en && !ev_loop_ret;
    if (ev_kind == EV_TRAP) begin
      cap_pair.origin  = ev_saved_pc;
      cap_pair.landing = ev_vector;
    end else begin
      cap_pair.origin  = ev_insn_addr;
      cap_pair.landing = ev_target;
    end
  end
endmodule

// File: rtl/trc_ring.sv
module trc_ring
  import trc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  trc_pair_t     push_pair,
  input  logic          pop,
  output trc_pair_t     head_pair,
  output logic [CW-1:0] count,
  output logic          empty
);
  trc_pair_t     mem [DEPTH];
  logic [PW-1:0] head_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          drop_oldest;
  logic [PW-1:0] waddr;

  assign full        = (cnt_q == CW'(DEPTH));
  assign empty       = (cnt_q == '0);
  assign drop_oldest = push && full && !pop;
  assign waddr       = flush ? '0 : wr_q;
  assign head_pair   = mem[head_q];
  assign count       = cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[waddr] <= push_pair;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      head_q <= '0;
      wr_q   <= push ? PW'(ptr_inc(0, DEPTH)) : '0;
      cnt_q  <= push ? CW'(1) : '0;
    end else begin
      if (push) wr_q <= PW'(ptr_inc(int'(wr_q), DEPTH));
      if (pop || drop_oldest) head_q <= PW'(ptr_inc(int'(head_q), DEPTH));
      cnt_q <= CW'(count_next(int'(cnt_q), push, pop, DEPTH));
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R5
  full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !flush) |=> full);

  // R10
  push_pop_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/branch_trace_queue.sv
module branch_trace_queue
  import trc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              ev_valid,
  input  logic              ev_kind,
  input  logic [TRC_AW-1:0] ev_insn_addr,
  input  logic [TRC_AW-1:0] ev_target,
  input  logic [TRC_AW-1:0] ev_saved_pc,
  input  logic [TRC_AW-1:0] ev_vector,
  input  logic              ev_loop_ret,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [TRC_AW-1:0] rd_data,
  output logic              rd_valid,
  output logic [CW-1:0]     fill_count
);
  logic      en_q;
  logic      en_rise;
  logic      cap_fire;
  trc_pair_t cap_pair;
  trc_pair_t head_pair;
  logic      q_empty;
  logic      pop_fire;

  assign en_rise  = trace_en && !en_q;
  assign pop_fire = rd_en && rd_sel && !q_empty;

  trc_select u_sel (
    .trace_en     (trace_en),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind_e'(ev_kind)),
    .ev_insn_addr (ev_insn_addr),
    .ev_target    (ev_target),
    .ev_saved_pc  (ev_saved_pc),
    .ev_vector    (ev_vector),
    .ev_loop_ret  (ev_loop_ret),
    .cap_fire     (cap_fire),
    .cap_pair     (cap_pair)
  );

  trc_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (en_rise),
    .push      (cap_fire),
    .push_pair (cap_pair),
    .pop       (pop_fire),
    .head_pair (head_pair),
    .count     (fill_count),
    .empty     (q_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      en_q     <= trace_en;
      rd_valid <= rd_en && !q_empty;
      if (rd_en && !q_empty) rd_data <= rd_sel ? head_pair.landing : head_pair.origin;
      else                   rd_data <= '0;
    end
  end

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en && !pop_fire) |=> $stable(fill_count));

  // R4
  loop_ret_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_loop_ret && !pop_fire && !en_rise) |=> $stable(fill_count));

  // R7
  origin_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !cap_fire && !en_rise) |=> $stable(fill_count));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fill_count == '0) |=> (!rd_valid && rd_data == '0));

  // R9
  reenable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !cap_fire) |=> (fill_count == '0));
endmodule

// File: tb/tb_branch_trace_queue.sv
`timescale 1ns/1ps
module tb_branch_trace_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trace_en, ev_valid, ev_kind, ev_loop_ret, rd_en, rd_sel;
  logic [31:0] ev_insn_addr, ev_target, ev_saved_pc, ev_vector;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [3:0]  fill_count;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mq[$];
  logic        en_prev;

  branch_trace_queue dut (
    .clk, .rst_n, .trace_en, .ev_valid, .ev_kind, .ev_insn_addr, .ev_target,
    .ev_saved_pc, .ev_vector, .ev_loop_ret, .rd_en, .rd_sel,
    .rd_data, .rd_valid, .fill_count
  );

  always #2 clk = ~clk;

  function automatic logic [63:0] pick_pair(input logic kind, input logic [31:0] ia,
                                            input logic [31:0] ta, input logic [31:0] sp,
                                            input logic [31:0] va);
    return kind ? {sp, va} : {ia, ta};
  endfunction

  task automatic check(input string tag, input logic [31:0] d_exp,
                       input logic v_exp, input logic [3:0] c_exp);
    checks++;
    if (rd_data !== d_exp || rd_valid !== v_exp || fill_count !== c_exp) begin
      fails++;
      $display("FAIL %s: data=%h valid=%b count=%0d expected data=%h valid=%b count=%0d",
               tag, rd_data, rd_valid, fill_count, d_exp, v_exp, c_exp);
    end
  endtask

  // One cycle: drive at a falling edge, model, check at the next falling edge
  task automatic step(input logic en, input logic v, input logic k, input logic lr,
                      input logic re, input logic rs, input string tag);
    logic [31:0] ia, ta, sp, va, d_exp;
    logic        v_exp, cap, rise;
    ia = $urandom; ta = $urandom; sp = $urandom; va = $urandom;
    trace_en = en; ev_valid = v; ev_kind = k; ev_loop_ret = lr;
    ev_insn_addr = ia; ev_target = ta; ev_saved_pc = sp; ev_vector = va;
    rd_en = re; rd_sel = rs;
    v_exp = re && mq.size() > 0;
    d_exp = v_exp ? (rs ? mq[0][31:0] : mq[0][63:32]) : 32'h0;
    cap  = v && en && !lr;
    rise = en && !en_prev;
    if (rise) mq.delete();
    else if (re && rs && mq.size() > 0) void'(mq.pop_front());
    if (cap) begin
      mq.push_back(pick_pair(k, ia, ta, sp, va));
      if (mq.size() > 8) void'(mq.pop_front());
    end
    en_prev = en;
    @(negedge clk);
    check(tag, d_exp, v_exp, 4'(mq.size()));
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    en_prev = 1'b0;
    rst_n = 1'b0; trace_en = 0; ev_valid = 0; ev_kind = 0; ev_loop_ret = 0;
    rd_en = 0; rd_sel = 0; ev_insn_addr = 0; ev_target = 0; ev_saved_pc = 0; ev_vector = 0;
    repeat (3) @(negedge clk);
    check("R11 reset", 32'h0, 1'b0, 4'd0);
    rst_n = 1'b1;
    // R1: events while disabled are dropped
    step(0, 1, 0, 0, 0, 0, "R1 disabled");
    step(0, 1, 1, 0, 1, 1, "R1 disabled read");
    // R2 / R3 captures after enabling
    step(1, 1, 0, 0, 0, 0, "R2 jump capture");
    step(1, 1, 1, 0, 0, 0, "R3 trap capture");
    // R4 loop return ignored
    step(1, 1, 0, 1, 0, 0, "R4 loop return");
    // R6/R7 origin reads twice, then landing read
    step(1, 0, 0, 0, 1, 0, "R6 origin view");
    step(1, 0, 0, 0, 1, 0, "R7 origin again");
    step(1, 0, 0, 0, 1, 1, "R7 landing pops");
    step(1, 0, 0, 0, 1, 0, "R3 origin is saved pc");
    step(1, 0, 0, 0, 1, 1, "R3 landing is vector");
    // R8 empty read
    step(1, 0, 0, 0, 1, 1, "R8 empty landing");
    step(1, 0, 0, 0, 1, 0, "R8 empty origin");
    step(1, 0, 0, 0, 0, 0, "R8 no read");
    // R5 overflow with 11 captures
    for (int i = 0; i < 11; i++) step(1, 1, i[0], 0, 0, 0, "R5 fill");
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, 0, 1, 0, "R5 oldest origin");
      step(1, 0, 0, 0, 1, 1, "R5 oldest landing");
    end
    // R10 capture and pop together on partial and full queue
    step(1, 1, 0, 0, 1, 1, "R10 partial");
    step(1, 1, 1, 0, 0, 0, "R10 refill");
    step(1, 1, 0, 0, 0, 0, "R10 refill");
    step(1, 1, 1, 0, 0, 0, "R10 refill");
    step(1, 1, 0, 0, 1, 1, "R10 full");
    step(1, 0, 0, 0, 1, 0, "R10 head after");
    // R9 re-enable flush, with and without a capture in the rising cycle
    step(0, 1, 0, 0, 1, 0, "R9 disabled read");
    step(1, 0, 0, 0, 0, 0, "R9 flush");
    step(1, 1, 0, 0, 0, 0, "R9 capture");
    step(0, 0, 0, 0, 0, 0, "R9 off");
    step(1, 1, 1, 0, 0, 0, "R9 flush with capture");
    step(1, 0, 0, 0, 1, 0, "R9 sole entry");
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r < 8'd245, ($urandom % 3) != 0, 1'($urandom), ($urandom % 8) == 0,
           ($urandom % 2) == 0, 1'($urandom), "R6 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule